// File: doc/BRIEF.md
# Multi-queue FIFO controller

The block keeps up to sixteen independent first-in first-out queues inside one shared word memory. While master reset is held, the memory is divided into equal regions of whole 256-word blocks, one region per queue. Either a loaded setting or a built-in default picks the queue count, the region size and the almost-empty and almost-full offsets. After reset, the write port names a target queue on every cycle and the read port names a source queue on every cycle. Each port can move one word per clock. Both ports run from the single clock `clk`.

The write side is a valid/ready stream. A word is taken when `wr_valid` and `wr_ready` are both high. If `wr_valid` is high while `wr_ready` is low, the word is dropped and `wr_rej` flags the drop. The read side is first-word-fall-through. The head word of the selected queue sits on `rd_data` with `rd_valid` high, and it is consumed when `rd_ready` is high in the same cycle. Raising `rd_ready` while `rd_valid` is low has no effect and raises `rd_rej`. A word written into an empty queue becomes visible on the read side one clock after it is accepted. Any queue can be emptied on its own with a partial reset.

Two 8-bit status buses report per-queue levels for a group of eight queues. The write side reports almost-full and the read side reports almost-empty. Each bus comes with the index of the group it is showing. In direct mode each bus shows the group that holds its port's queue. In polled mode both buses step through the active groups, one group per clock.

Top module: `mqfifo_ctrl`

## Requirements
- R1: On each clock edge with `rst_n` low, a high `cfg_load` sets the queue count to `cfg_nq`, with 0 read as 1 and any value above 16 read as 16. A low `cfg_load` gives 16 queues. Queues with an index at or above the count are unconfigured: they accept no writes and never show read data.
- R2: Each configured queue holds `cfg_bpq` blocks of 256 words, with 0 read as 1. The default is the pool (16 blocks) divided evenly, which is one block per queue. A queue accepts exactly its capacity before it reports full.
- R3: `wr_ready` is high exactly when `wr_q` names a configured queue, that queue holds fewer words than its capacity, and that queue is not being partially reset in the same cycle.
- R4: A write offered with `wr_ready` low changes no queue, and `wr_rej` is high in that cycle.
- R5: Every accepted write appends its word to the tail of the addressed queue. One write can be accepted per clock.
- R6: Whenever the selected read queue is non-empty, `rd_valid` is high and `rd_data` holds that queue's oldest word, with no strobe needed. `rd_valid` and `rd_ready` high together remove that word at the clock edge.
- R7: The read queue selection is registered. A new value on `rd_q` governs `rd_valid` and `rd_data` from the following clock on.
- R8: A read request with `rd_valid` low removes nothing, and `rd_rej` is high in that cycle.
- R9: `prst` high with `prst_q` empties that one queue at the clock edge, and every other queue is left intact. In that cycle the named queue shows `wr_ready` low and, if it is the read selection, `rd_valid` low.
- R10: A queue's almost-full bit is 1 when level + full offset >= capacity. Its almost-empty bit is 1 when level <= empty offset. Both offsets come from the configuration when it is loaded and are 8 otherwise. Unconfigured queues read 1 on both buses.
- R11: With `stat_poll` low, bit j of `paf_bus` is queue 8·g+j with g = `wr_q` div 8 on `paf_grp`. Bit j of `pae_bus` is queue 8·g+j with g = the registered read selection div 8 on `pae_grp`.
- R12: With `stat_poll` high, both buses show one shared group counter. The counter is 0 in the first polled cycle, advances by one each clock, and wraps after group ceil(count/8)−1. Dropping `stat_poll` returns it to 0.
- R13: A write and a read on the same queue in the same cycle leave its level unchanged and preserve word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, active low, synchronous; configuration is captured while low |
| cfg_load | input | 1 | Use the cfg_* values at reset instead of the defaults |
| cfg_nq | input | 5 | Requested queue count |
| cfg_bpq | input | 5 | Blocks per queue |
| cfg_ae_ofs | input | 12 | Almost-empty offset in words |
| cfg_af_ofs | input | 12 | Almost-full offset in words |
| wr_q | input | 4 | Queue addressed by the write stream |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 36 | Write word |
| wr_ready | output | 1 | Addressed queue can take a word |
| wr_rej | output | 1 | Offered write dropped this cycle |
| rd_q | input | 4 | Queue to read from, effective next clock |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_valid | output | 1 | Head word present |
| rd_data | output | 36 | Head word of the selected queue |
| rd_rej | output | 1 | Read request while nothing is present |
| prst | input | 1 | Partial reset strobe |
| prst_q | input | 4 | Queue to partially reset |
| stat_poll | input | 1 | 0 direct status, 1 polled status |
| paf_bus | output | 8 | Almost-full bits of one group |
| paf_grp | output | 1 | Group shown on paf_bus |
| pae_bus | output | 8 | Almost-empty bits of one group |
| pae_grp | output | 1 | Group shown on pae_bus |

## Verification
The assertions assume the configuration is legal: queue count times blocks per queue fits in the 16-block pool, and both offsets are no larger than a queue's capacity. They also assume the cfg_* inputs hold steady while reset is low. The stimulus uses only the default setup, a five-queue setup of two blocks each, and a one-queue setup, each with offsets well below capacity. The bench drives every input away from the clock edge, so no input changes at the moment it is sampled. Traffic to unconfigured queues, full queues and empty queues is deliberate, because the design must take it without harm.

// File: rtl/mq_pkg.sv
package mq_pkg;

  typedef enum logic {
    STAT_DIRECT = 1'b0,
    STAT_POLL   = 1'b1
  } stat_mode_e;

  function automatic int unsigned bits_for(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/mq_cfg.sv
module mq_cfg #(
  parameter int NQ_MAX      = 16,
  parameter int BLK_WORDS   = 256,
  parameter int POOL_BLOCKS = 16,
  parameter int OFS_W       = 12,
  parameter int DEF_AE      = 8,
  parameter int DEF_AF      = 8,
  parameter int NW          = 5,
  parameter int BW          = 5,
  parameter int CW          = 13,
  parameter int GW          = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [NW-1:0]    cfg_nq,
  input  logic [BW-1:0]    cfg_bpq,
  input  logic [OFS_W-1:0] cfg_ae_ofs,
  input  logic [OFS_W-1:0] cfg_af_ofs,
  output logic [NW-1:0]    nq_r,
  output logic [CW-1:0]    cap_r,
  output logic [OFS_W-1:0] ae_r,
  output logic [OFS_W-1:0] af_r,
  output logic [GW:0]      ngrp_r
);

  localparam int DEF_BPQ = (POOL_BLOCKS / NQ_MAX > 0) ? POOL_BLOCKS / NQ_MAX : 1;

  logic [NW-1:0] nq_fix;
  logic [BW-1:0] bpq_fix;
  logic [NW-1:0] nq_pick;

  always_comb begin
    if (cfg_nq == '0)                 nq_fix = NW'(1);
    else if (cfg_nq > NW'(NQ_MAX))    nq_fix = NW'(NQ_MAX);
    else                              nq_fix = cfg_nq;
    bpq_fix = (cfg_bpq == '0) ? BW'(1) : cfg_bpq;
    nq_pick = cfg_load ? nq_fix : NW'(NQ_MAX);
  end

  // Captured on every edge while master reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nq_r   <= nq_pick;
      ngrp_r <= (GW+1)'((int'(nq_pick) + 7) / 8);
      if (cfg_load) begin
        cap_r <= CW'(int'(bpq_fix) * BLK_WORDS);
        ae_r  <= cfg_ae_ofs;
        af_r  <= cfg_af_ofs;
      end else begin
        cap_r <= CW'(DEF_BPQ * BLK_WORDS);
        ae_r  <= OFS_W'(DEF_AE);
        af_r  <= OFS_W'(DEF_AF);
      end
    end
  end

endmodule

// File: rtl/mq_qstate.sv
module mq_qstate #(
  parameter int NQ_MAX = 16,
  parameter int QW     = 4,
  parameter int PW     = 12,
  parameter int CW     = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CW-1:0]                cap,
  input  logic                         push,
  input  logic [QW-1:0]                push_q,
  input  logic                         pop,
  input  logic [QW-1:0]                pop_q,
  input  logic                         prst,
  input  logic [QW-1:0]                prst_q,
  output logic [NQ_MAX-1:0][CW-1:0]    cnt,
  output logic [NQ_MAX-1:0][PW-1:0]    wptr,
  output logic [NQ_MAX-1:0][PW-1:0]    rptr
);

  // Offsets run 0 .. cap-1 inside a queue's own region.
  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p, input logic [CW-1:0] lim);
    return ({1'b0, p} == lim - CW'(1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < NQ_MAX; i++) begin : g_q
    logic          hit_w, hit_r, hit_c;
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] lvl;

    assign hit_w = push && (push_q == QW'(i));
    assign hit_r = pop  && (pop_q  == QW'(i));
    assign hit_c = prst && (prst_q == QW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || hit_c) begin
        wp  <= '0;
        rp  <= '0;
        lvl <= '0;
      end else begin
        if (hit_w) wp <= advance(wp, cap);
        if (hit_r) rp <= advance(rp, cap);
        lvl <= lvl + CW'(hit_w) - CW'(hit_r);
      end
    end

    assign cnt[i]  = lvl;
    assign wptr[i] = wp;
    assign rptr[i] = rp;
  end

endmodule

// File: rtl/mq_status.sv
module mq_status
  import mq_pkg::*;
#(
  parameter int NQ_MAX = 16,
  parameter int QW     = 4,
  parameter int CW     = 13,
  parameter int OFS_W  = 12,
  parameter int NW     = 5,
  parameter int GW     = 1,
  parameter int NGRP   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NQ_MAX-1:0][CW-1:0] cnt,
  input  logic [CW-1:0]             cap,
  input  logic [OFS_W-1:0]          ae_ofs,
  input  logic [OFS_W-1:0]          af_ofs,
  input  logic [NW-1:0]             nq,
  input  logic [GW:0]               ngrp,
  input  logic                      stat_poll,
  input  logic [QW-1:0]             wr_q,
  input  logic [QW-1:0]             rd_sel,
  output logic [7:0]                paf_bus,
  output logic [GW-1:0]             paf_grp,
  output logic [7:0]                pae_bus,
  output logic [GW-1:0]             pae_grp
);

  localparam int NPAD = NGRP * 8;
  localparam int EW   = ((CW > OFS_W) ? CW : OFS_W) + 1;

  stat_mode_e    mode;
  logic [GW-1:0] pgrp;
  logic [NPAD-1:0] af_v, ae_v;

  assign mode = stat_mode_e'(stat_poll);

  for (genvar i = 0; i < NPAD; i++) begin : g_flag
    if (i < NQ_MAX) begin : g_real
      logic live;
      assign live    = NW'(i) < nq;
      assign af_v[i] = !live || (EW'(cnt[i]) + EW'(af_ofs) >= EW'(cap));
      assign ae_v[i] = !live || (EW'(cnt[i]) <= EW'(ae_ofs));
    end else begin : g_pad
      assign af_v[i] = 1'b1;
      assign ae_v[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode == STAT_DIRECT)          pgrp <= '0;
    else if ((GW+1)'(pgrp) + 1'b1 >= ngrp)      pgrp <= '0;
    else                                        pgrp <= pgrp + GW'(1);
  end

  always_comb begin
    if (mode == STAT_POLL) begin
      paf_grp = pgrp;
      pae_grp = pgrp;
    end else begin
      paf_grp = GW'(wr_q >> 3);
      pae_grp = GW'(rd_sel >> 3);
    end
    paf_bus = af_v[{paf_grp, 3'b000} +: 8];
    pae_bus = ae_v[{pae_grp, 3'b000} +: 8];
  end

endmodule

// File: rtl/mqfifo_ctrl.sv
module mqfifo_ctrl
  import mq_pkg::*;
#(
  parameter int NQ_MAX      = 16,
  parameter int DW          = 36,
  parameter int BLK_WORDS   = 256,
  parameter int POOL_BLOCKS = 16,
  parameter int OFS_W       = 12,
  parameter int DEF_AE      = 8,
  parameter int DEF_AF      = 8,
  localparam int POOL_WORDS = BLK_WORDS * POOL_BLOCKS,
  localparam int PW         = bits_for(POOL_WORDS),
  localparam int CW         = PW + 1,
  localparam int QW         = bits_for(NQ_MAX),
  localparam int NW         = $clog2(NQ_MAX + 1),
  localparam int BW         = $clog2(POOL_BLOCKS + 1),
  localparam int NGRP       = ceil_div(NQ_MAX, 8),
  localparam int GW         = bits_for(NGRP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [NW-1:0]    cfg_nq,
  input  logic [BW-1:0]    cfg_bpq,
  input  logic [OFS_W-1:0] cfg_ae_ofs,
  input  logic [OFS_W-1:0] cfg_af_ofs,
  input  logic [QW-1:0]    wr_q,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  output logic             wr_rej,
  input  logic [QW-1:0]    rd_q,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_rej,
  input  logic             prst,
  input  logic [QW-1:0]    prst_q,
  input  logic             stat_poll,
  output logic [7:0]       paf_bus,
  output logic [GW-1:0]    paf_grp,
  output logic [7:0]       pae_bus,
  output logic [GW-1:0]    pae_grp
);

  logic [NW-1:0]             nq_r;
  logic [CW-1:0]             cap_r;
  logic [OFS_W-1:0]          ae_r, af_r;
  logic [GW:0]               ngrp_r;
  logic [NQ_MAX-1:0][CW-1:0] q_cnt;
  logic [NQ_MAX-1:0][PW-1:0] q_wptr, q_rptr;
  logic [QW-1:0]             rd_sel;
  logic                      push, pop;
  logic [PW-1:0]             waddr, raddr;
  logic [DW-1:0]             mem [POOL_WORDS];

  mq_cfg #(
    .NQ_MAX(NQ_MAX), .BLK_WORDS(BLK_WORDS), .POOL_BLOCKS(POOL_BLOCKS),
    .OFS_W(OFS_W), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF),
    .NW(NW), .BW(BW), .CW(CW), .GW(GW)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_nq(cfg_nq),
    .cfg_bpq(cfg_bpq), .cfg_ae_ofs(cfg_ae_ofs), .cfg_af_ofs(cfg_af_ofs),
    .nq_r(nq_r), .cap_r(cap_r), .ae_r(ae_r), .af_r(af_r), .ngrp_r(ngrp_r)
  );

  // Read selection takes effect one clock after it is presented.
  always_ff @(posedge clk) begin
    if (!rst_n) rd_sel <= '0;
    else        rd_sel <= rd_q;
  end

  always_comb begin
    wr_ready = (NW'(wr_q) < nq_r) && (q_cnt[wr_q] != cap_r)
               && !(prst && prst_q == wr_q);
    rd_valid = (NW'(rd_sel) < nq_r) && (q_cnt[rd_sel] != '0)
               && !(prst && prst_q == rd_sel);
    push   = wr_valid && wr_ready;
    pop    = rd_valid && rd_ready;
    wr_rej = wr_valid && !wr_ready;
    rd_rej = rd_ready && !rd_valid;
    waddr  = PW'(CW'(wr_q) * cap_r) + q_wptr[wr_q];
    raddr  = PW'(CW'(rd_sel) * cap_r) + q_rptr[rd_sel];
  end

  mq_qstate #(.NQ_MAX(NQ_MAX), .QW(QW), .PW(PW), .CW(CW)) i_qstate (
    .clk(clk), .rst_n(rst_n), .cap(cap_r),
    .push(push), .push_q(wr_q), .pop(pop), .pop_q(rd_sel),
    .prst(prst), .prst_q(prst_q),
    .cnt(q_cnt), .wptr(q_wptr), .rptr(q_rptr)
  );

  always_ff @(posedge clk) begin
    if (push) mem[waddr] <= wr_data;
  end

  assign rd_data = mem[raddr];

  mq_status #(
    .NQ_MAX(NQ_MAX), .QW(QW), .CW(CW), .OFS_W(OFS_W),
    .NW(NW), .GW(GW), .NGRP(NGRP)
  ) i_status (
    .clk(clk), .rst_n(rst_n), .cnt(q_cnt), .cap(cap_r),
    .ae_ofs(ae_r), .af_ofs(af_r), .nq(nq_r), .ngrp(ngrp_r),
    .stat_poll(stat_poll), .wr_q(wr_q), .rd_sel(rd_sel),
    .paf_bus(paf_bus), .paf_grp(paf_grp), .pae_bus(pae_bus), .pae_grp(pae_grp)
  );

endmodule

// File: rtl/mq_chk.sv
module mq_chk #(
  parameter int NQ_MAX = 16,
  parameter int QW     = 4,
  parameter int CW     = 13,
  parameter int NW     = 5,
  parameter int GW     = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic [QW-1:0]             wr_q,
  input logic                      rd_valid,
  input logic                      rd_ready,
  input logic [QW-1:0]             rd_sel,
  input logic                      prst,
  input logic [QW-1:0]             prst_q,
  input logic                      stat_poll,
  input logic [NQ_MAX-1:0][CW-1:0] q_cnt,
  input logic [CW-1:0]             cap_r,
  input logic [NW-1:0]             nq_r,
  input logic [GW:0]               ngrp_r,
  input logic [GW-1:0]             pae_grp
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (NW'(wr_q) < nq_r) |-> (q_cnt[wr_q] <= cap_r));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt[wr_q] == cap_r) |-> !wr_ready);

  a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(rd_valid && rd_ready && rd_sel == wr_q))
    |=> (q_cnt[$past(wr_q)] == $past(q_cnt[wr_q]) + CW'(1)));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !(wr_valid && wr_ready && wr_q == rd_sel))
    |=> (q_cnt[$past(rd_sel)] == $past(q_cnt[rd_sel]) - CW'(1)));

  a_r9_prst_empties: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> (q_cnt[$past(prst_q)] == '0));

  a_r12_poll_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    stat_poll |-> ((GW+1)'(pae_grp) < ngrp_r));

endmodule

bind mqfifo_ctrl mq_chk #(
  .NQ_MAX(NQ_MAX), .QW(QW), .CW(CW), .NW(NW), .GW(GW)
) i_mq_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_q(wr_q), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel),
  .prst(prst), .prst_q(prst_q), .stat_poll(stat_poll), .q_cnt(q_cnt),
  .cap_r(cap_r), .nq_r(nq_r), .ngrp_r(ngrp_r), .pae_grp(pae_grp)
);

// File: tb/test_mqfifo_ctrl.sv
module test_mqfifo_ctrl;

  localparam int NQ    = 16;
  localparam int BLK   = 256;
  localparam int POOLB = 16;

  logic        clk = 1'b0;
  logic        rst_n, cfg_load;
  logic [4:0]  cfg_nq, cfg_bpq;
  logic [11:0] cfg_ae_ofs, cfg_af_ofs;
  logic [3:0]  wr_q, rd_q, prst_q;
  logic        wr_valid, rd_ready, prst, stat_poll;
  logic [35:0] wr_data;
  logic        wr_ready, wr_rej, rd_valid, rd_rej;
  logic [35:0] rd_data;
  logic [7:0]  paf_bus, pae_bus;
  logic [0:0]  paf_grp, pae_grp;

  always #2 clk = ~clk;

  mqfifo_ctrl i_mqfifo_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_nq(cfg_nq),
    .cfg_bpq(cfg_bpq), .cfg_ae_ofs(cfg_ae_ofs), .cfg_af_ofs(cfg_af_ofs),
    .wr_q(wr_q), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .wr_rej(wr_rej), .rd_q(rd_q), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_rej(rd_rej), .prst(prst), .prst_q(prst_q),
    .stat_poll(stat_poll), .paf_bus(paf_bus), .paf_grp(paf_grp),
    .pae_bus(pae_bus), .pae_grp(pae_grp)
  );

  int n_chk = 0, n_fail = 0, seq = 0;
  bit done = 0;
  int nq_m, cap_m, ae_m, af_m, rs_m, pg_m;
  logic [35:0] mdl [NQ][$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_af(int q);
    if (q >= nq_m) return 1'b1;
    return (mdl[q].size() + af_m >= cap_m);
  endfunction

  function automatic bit m_ae(int q);
    if (q >= nq_m) return 1'b1;
    return (mdl[q].size() <= ae_m);
  endfunction

  function automatic logic [7:0] m_bus(int g, bit full_side);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[j] = full_side ? m_af(g*8 + j) : m_ae(g*8 + j);
    return b;
  endfunction

  task automatic idle();
    wr_valid = 0; rd_ready = 0; prst = 0; stat_poll = 0;
    wr_q = 0; rd_q = 0; prst_q = 0; wr_data = '0;
  endtask

  // One clock: settle, compare against the model, update the model, advance.
  task automatic cyc(string tag);
    int wq, pq, pg_w, pg_r, ng;
    bit wrdy, rvld;
    string gt;
    #1;
    wq = int'(wr_q); pq = int'(prst_q);
    wrdy = (wq < nq_m) && (mdl[wq].size() < cap_m) && !(prst && pq == wq);
    rvld = (rs_m < nq_m) && (mdl[rs_m].size() > 0) && !(prst && pq == rs_m);
    chk({tag, "/R3"}, "wr_ready", 64'(wr_ready), 64'(wrdy));
    chk({tag, "/R4"}, "wr_rej", 64'(wr_rej), 64'(wr_valid && !wrdy));
    chk({tag, "/R6"}, "rd_valid", 64'(rd_valid), 64'(rvld));
    chk({tag, "/R8"}, "rd_rej", 64'(rd_rej), 64'(rd_ready && !rvld));
    if (rvld) chk({tag, "/R6"}, "rd_data", 64'(rd_data), 64'(mdl[rs_m][0]));
    pg_w = stat_poll ? pg_m : wq / 8;
    pg_r = stat_poll ? pg_m : rs_m / 8;
    gt = stat_poll ? "/R12" : "/R11";
    chk({tag, gt}, "paf_grp", 64'(paf_grp), 64'(pg_w));
    chk({tag, gt}, "pae_grp", 64'(pae_grp), 64'(pg_r));
    chk({tag, "/R10"}, "paf_bus", 64'(paf_bus), 64'(m_bus(pg_w, 1'b1)));
    chk({tag, "/R10"}, "pae_bus", 64'(pae_bus), 64'(m_bus(pg_r, 1'b0)));
    if (rvld && rd_ready) void'(mdl[rs_m].pop_front());
    if (wr_valid && wrdy) mdl[wq].push_back(wr_data);
    if (prst) mdl[pq].delete();
    ng = (nq_m + 7) / 8;
    rs_m = int'(rd_q);
    pg_m = !stat_poll ? 0 : ((pg_m + 1 >= ng) ? 0 : pg_m + 1);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit ld, int n, int b, int ae, int af);
    idle();
    rst_n = 0; cfg_load = ld; cfg_nq = 5'(n); cfg_bpq = 5'(b);
    cfg_ae_ofs = 12'(ae); cfg_af_ofs = 12'(af);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    if (ld) begin
      nq_m  = (n == 0) ? 1 : ((n > NQ) ? NQ : n);
      cap_m = ((b == 0) ? 1 : b) * BLK;
      ae_m  = ae; af_m = af;
    end else begin
      nq_m = NQ; cap_m = (POOLB / NQ) * BLK; ae_m = 8; af_m = 8;
    end
    for (int q = 0; q < NQ; q++) mdl[q].delete();
    rs_m = 0; pg_m = 0;
  endtask

  task automatic put(int q);
    wr_q = 4'(q); wr_valid = 1; seq++; wr_data = {4'(q), 32'(seq)};
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Default configuration
    do_reset(1'b0, 0, 0, 0, 0);
    cyc("R1");                                  // reset state
    for (int i = 0; i < 20; i++) begin put(i % 4); cyc("R5"); end
    idle(); rd_q = 1; cyc("R7");                // selection lands next clock
    rd_ready = 1; for (int i = 0; i < 3; i++) cyc("R6");
    rd_q = 2; cyc("R7"); cyc("R6");
    rd_q = 9; cyc("R8"); cyc("R8"); rd_ready = 0;
    for (int i = 0; i < 262; i++) begin put(3); cyc("R2"); end
    wr_valid = 0; cyc("R4");
    rd_q = 2; cyc("R13");
    for (int i = 0; i < 50; i++) begin put(2); rd_ready = 1; cyc("R13"); end
    idle();
    for (int i = 0; i < 12; i++) begin put(8 + i % 4); cyc("R11"); end
    wr_valid = 0; wr_q = 12; rd_q = 10; cyc("R11"); cyc("R11");
    stat_poll = 1; for (int i = 0; i < 6; i++) cyc("R12");
    stat_poll = 0; cyc("R12");
    rd_q = 3; cyc("R9");
    prst = 1; prst_q = 3; put(3); rd_ready = 1; cyc("R9");
    idle(); rd_q = 3; cyc("R9"); put(3); cyc("R9");
    wr_valid = 0; rd_q = 9; cyc("R9"); cyc("R9");

    // Five queues of two blocks, own offsets
    do_reset(1'b1, 5, 2, 4, 16);
    cyc("R1");
    for (int i = 0; i < 10; i++) begin put(6 + i % 3); cyc("R1"); end
    for (int i = 0; i < 520; i++) begin put(4); cyc("R2"); end
    wr_valid = 0; stat_poll = 1; for (int i = 0; i < 4; i++) cyc("R12");
    stat_poll = 0; rd_q = 4; cyc("R7");
    for (int i = 0; i < 1200; i++) begin
      if ($urandom_range(0, 2) != 0) put(4); else wr_valid = 0;
      rd_ready = ($urandom_range(0, 1) == 1);
      cyc("R5");
    end
    idle();

    // Queue count and block count of zero
    do_reset(1'b1, 0, 0, 2, 2);
    for (int i = 0; i < 8; i++) begin put(i % 2); cyc("R1"); end
    wr_valid = 0; rd_ready = 1; for (int i = 0; i < 6; i++) cyc("R6");
    idle();

    // Default configuration under mixed random traffic
    do_reset(1'b0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) != 0) put($urandom_range(0, 15)); else wr_valid = 0;
      rd_q      = 4'($urandom_range(0, 15));
      rd_ready  = ($urandom_range(0, 1) == 1);
      prst      = ($urandom_range(0, 63) == 0);
      prst_q    = 4'($urandom_range(0, 15));
      stat_poll = ((i / 50) % 3 == 2);
      cyc("R9");
    end
    idle(); cyc("R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule